// File: doc/BRIEF.md
# Strided Pattern Fill Engine

The engine writes one constant pattern into memory a programmed number of times. A single start pulse loads five values: a destination base address, a signed two's-complement stride in bytes, a repeat count, a 32-bit pattern and an element-size code. The engine then issues one write per element on a memory port. The port carries byte enables and waits for an acknowledge on each write. After every acknowledged write except the last, the destination address moves by the stride. A positive stride fills forwards, a negative stride fills backwards, and a stride equal to the line pitch fills a column.

When the run ends, the address output holds the address of the last element written, not that address plus the stride. The count output reads zero. A one-cycle done pulse marks the end of the run. The stride and the pattern are held in private copies, so the run never changes them.

The controller has three states. IDLE waits for a start pulse. STORE holds one write request until it is acknowledged. DONE produces the completion pulse. There are five transitions:
- IDLE→STORE on a start pulse with a non-zero count.
- IDLE→DONE on a start pulse with a zero count.
- STORE→STORE on an acknowledge when more elements remain.
- STORE→DONE on the acknowledge of the final element.
- DONE→IDLE unconditionally.

Top module: `stride_fill`

## Requirements
- R1: While reset is held, and after it is released, the engine has busy, done and mem_req low, and addr_out and count_out zero.
- R2: A start pulse accepted with count N>0 produces exactly N acknowledged writes. The first write goes to the base address. mem_req is high only in the STORE state.
- R3: After each acknowledged write that is not the last, the next write address equals the previous address plus the stride, wrapping modulo 2^ADDR_W. Negative strides are allowed.
- R4: While a write is pending without an acknowledge, mem_req, mem_addr, mem_be and mem_wdata hold their values.
- R5: When done is high, addr_out holds the address of the last write and count_out is zero. During a run, count_out shows the writes still to be acknowledged.
- R6: A start pulse with count zero performs no write. It raises done in the next cycle, and addr_out then equals the base address.
- R7: done is high for exactly one cycle, in the cycle after the final write is acknowledged.
- R8: Byte lanes (4-lane bus) follow the size code:
  - code 0 (1 byte): mem_be = 1 << addr[1:0], and pattern[7:0] is repeated on all lanes.
  - code 1 (2 bytes): mem_be = 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1. addr[0] is ignored, and pattern[15:0] is repeated on both halves.
  - codes 2 and 3 (4 bytes): mem_be = 4'b1111 and mem_wdata = pattern.
- R9: A start pulse while busy is ignored. The sequence of writes, the final address and the count continue unchanged.
- R10: Base, stride, count, pattern and size are captured on the accepted start. Changing those inputs during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only in IDLE |
| base_addr | input | ADDR_W | First destination byte address |
| stride | input | ADDR_W | Signed two's-complement byte step |
| count | input | CNT_W | Number of writes |
| pattern | input | 32 | Fill value |
| size | input | 2 | Element size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| mem_req | output | 1 | Write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_wdata | output | DATA_W | Write data on byte lanes |
| mem_ack | input | 1 | Write acknowledge |
| busy | output | 1 | High outside IDLE |
| done | output | 1 | One-cycle completion pulse |
| addr_out | output | ADDR_W | Current or last written address |
| count_out | output | CNT_W | Writes remaining, zero after completion |

## Verification
The bench targets five corner cases:
- The final address after the last acknowledge. A design that stepped once more would report the last address plus the stride.
- A zero count. A faulty design would either issue a write or underflow the counter into a very long run.
- Two-byte writes at odd addresses and one-byte writes at every lane offset. A lane decoder that used the wrong address bits would enable the wrong byte lanes.
- Strides that are negative or that wrap past the top of the address space.
- Start pulses and input changes in the middle of a run. A design that reloaded on either would change the sequence of writes.

Acknowledges are irregular, so held requests are checked for stability.

// File: rtl/stride_fill_pkg.sv
package stride_fill_pkg;

    typedef enum logic [1:0] {
        SZ_1B   = 2'd0,
        SZ_2B   = 2'd1,
        SZ_4B   = 2'd2,
        SZ_4B_X = 2'd3
    } esize_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_DONE  = 2'd2
    } fstate_t;

endpackage

// File: rtl/stride_fill_lanes.sv
module stride_fill_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] lo_addr,
    input  logic [1:0]                  shift,
    input  logic [31:0]                 pattern,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           wdata
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    // Mask that selects the byte inside one element: 0, 1 or 3
    logic [2:0] elem_mask;
    assign elem_mask = (3'b001 << shift) - 3'b001;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LANE_BITS-1:0] LI = LANE_BITS'(i);
        logic [1:0] bsel;
        assign bsel            = 2'(i) & elem_mask[1:0];
        assign be[i]           = (LI >> shift) == (lo_addr >> shift);
        assign wdata[8*i +: 8] = pattern[8*bsel +: 8];
    end

endmodule

// File: rtl/stride_fill_path.sv
module stride_fill_path #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              finish,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  count,
    input  logic [31:0]       pattern,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remain,
    output logic [31:0]       pat_q,
    output logic [1:0]        shift_q,
    output logic              last
);
    import stride_fill_pkg::*;

    logic [ADDR_W-1:0] stride_q;
    logic [1:0]        shift_in;

    // Code 3 is folded onto the 4-byte element
    assign shift_in = (esize_t'(size) == SZ_4B_X) ? 2'd2 : size;
    assign last     = (remain == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            stride_q <= '0;
            pat_q    <= '0;
            shift_q  <= '0;
        end else if (load) begin
            cur_addr <= base_addr;
            remain   <= count;
            stride_q <= stride;
            pat_q    <= pattern;
            shift_q  <= shift_in;
        end else if (step) begin
            cur_addr <= cur_addr + stride_q;
            remain   <= remain - CNT_W'(1);
        end else if (finish) begin
            remain   <= '0;
        end
    end

    // R3: an intermediate acknowledge moves the address by the held stride
    p_step_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cur_addr == $past(cur_addr) + $past(stride_q));

    // R5: the final acknowledge keeps the address and clears the count
    p_finish_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (remain == '0) && $stable(cur_addr));

endmodule

// File: rtl/stride_fill_ctrl.sv
module stride_fill_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic ack,
    input  logic last,
    output logic load,
    output logic step,
    output logic finish,
    output logic req,
    output logic busy,
    output logic done
);
    import stride_fill_pkg::*;

    fstate_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = cnt_zero ? ST_DONE : ST_STORE;
            ST_STORE: if (ack && last) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        req    = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_STORE: begin
                req    = 1'b1;
                step   = ack && !last;
                finish = ack && last;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R7: completion pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: zero count goes straight to completion without a request
    p_zero_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && cnt_zero) |=> done && !req);

    // R9: a run in progress is never abandoned back to idle
    p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && !ack) |=> state == ST_STORE);

endmodule

// File: rtl/stride_fill.sv
module stride_fill #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [ADDR_W-1:0]   stride,
    input  logic [CNT_W-1:0]    count,
    input  logic [31:0]         pattern,
    input  logic [1:0]          size,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   addr_out,
    output logic [CNT_W-1:0]    count_out
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    logic              load, step, finish, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [31:0]       pat_q;
    logic [1:0]        shift_q;

    stride_fill_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_zero (count == '0),
        .ack      (mem_ack),
        .last     (last),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .req      (mem_req),
        .busy     (busy),
        .done     (done)
    );

    stride_fill_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .finish    (finish),
        .base_addr (base_addr),
        .stride    (stride),
        .count     (count),
        .pattern   (pattern),
        .size      (size),
        .cur_addr  (cur_addr),
        .remain    (remain),
        .pat_q     (pat_q),
        .shift_q   (shift_q),
        .last      (last)
    );

    stride_fill_lanes #(.DATA_W(DATA_W)) u_lanes (
        .lo_addr (cur_addr[LANE_BITS-1:0]),
        .shift   (shift_q),
        .pattern (pat_q),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    assign mem_addr  = cur_addr;
    assign addr_out  = cur_addr;
    assign count_out = remain;

    // R4: a pending write is held until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_be) && $stable(mem_wdata));

    // R8: a one-byte element enables exactly one lane
    p_byte_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && shift_q == 2'd0) |-> $countones(mem_be) == 1);

    // R8: every request enables at least one lane
    p_lane_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_be != '0);

    // R5: completion reports a zero count
    p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> count_out == '0);

endmodule

// File: tb/stride_fill_tb_top.sv
module stride_fill_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] in_base = '0, in_stride = '0, in_pat = '0;
    logic [15:0] in_cnt = '0;
    logic [1:0]  in_size = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req, busy, done;
    logic [31:0] mem_addr, mem_wdata, addr_out;
    logic [3:0]  mem_be;
    logic [15:0] count_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stride_fill dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(in_base),
        .stride(in_stride), .count(in_cnt), .pattern(in_pat), .size(in_size),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy), .done(done),
        .addr_out(addr_out), .count_out(count_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [31:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [31:0] p);
        case (sz)
            2'd0:    return {4{p[7:0]}};
            2'd1:    return {2{p[15:0]}};
            default: return p;
        endcase
    endfunction

    // Behavioural reference: 0 idle, 1 writing, 2 completing
    int          m_state = 0;
    logic [31:0] m_addr = '0, m_stride = '0, m_pat = '0;
    int          m_rem = 0;
    logic [1:0]  m_size = '0;
    int          nst = 0;
    bit          hold_chk = 0;
    logic [31:0] h_addr, h_data;
    logic [3:0]  h_be;

    always @(posedge clk) begin
        hold_chk = mem_req && !mem_ack;
        h_addr = mem_addr; h_be = mem_be; h_data = mem_wdata;
        if (!rst_n) begin
            m_state = 0; m_addr = '0; m_rem = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_addr = in_base; m_stride = in_stride; m_pat = in_pat;
                    m_size = in_size; m_rem = int'(in_cnt); nst = 0;
                    m_state = (in_cnt == 0) ? 2 : 1;
                end
                1: if (mem_ack) begin
                    nst++;
                    if (m_rem == 1) begin m_rem = 0; m_state = 2; end
                    else begin m_addr = m_addr + m_stride; m_rem--; end
                end
                default: m_state = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(mem_req == (m_state == 1), "R2 mem_req", 32'(mem_req), 32'(m_state == 1));
            check(done == (m_state == 2), "R7 done", 32'(done), 32'(m_state == 2));
            check(busy == (m_state != 0), "R9 busy", 32'(busy), 32'(m_state != 0));
            check(addr_out == m_addr, "R3 addr_out", addr_out, m_addr);
            check(count_out == 16'(m_rem), "R5 count_out", 32'(count_out), 32'(m_rem));
            if (m_state == 1) begin
                check(mem_addr == m_addr, "R3 mem_addr", mem_addr, m_addr);
                check(mem_be == exp_be(m_size, m_addr), "R8 mem_be",
                      32'(mem_be), 32'(exp_be(m_size, m_addr)));
                check(mem_wdata == exp_data(m_size, m_pat), "R8 mem_wdata",
                      mem_wdata, exp_data(m_size, m_pat));
            end
            if (hold_chk)
                check(mem_req && mem_addr == h_addr && mem_be == h_be && mem_wdata == h_data,
                      "R4 hold", mem_addr, h_addr);
        end
    end

    // Irregular acknowledge
    always @(negedge clk) mem_ack = ($urandom_range(0, 3) != 0);

    task automatic launch(input logic [31:0] b, input logic [31:0] s,
                          input logic [15:0] n, input logic [31:0] p, input logic [1:0] z);
        @(negedge clk);
        in_base = b; in_stride = s; in_cnt = n; in_pat = p; in_size = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input logic [31:0] b, input logic [31:0] s,
                              input logic [15:0] n, input string tag);
        logic [31:0] fin;
        while (!done) @(negedge clk);
        fin = (n == 0) ? b : b + (32'(n) - 32'd1) * s;
        check(nst == int'(n), {tag, " store count"}, 32'(nst), 32'(n));
        check(addr_out == fin, {tag, " final address"}, addr_out, fin);
        check(count_out == 16'd0, {tag, " final count"}, 32'(count_out), 32'd0);
        @(negedge clk);
    endtask

    task automatic run(input logic [31:0] b, input logic [31:0] s,
                       input logic [15:0] n, input logic [31:0] p, input logic [1:0] z,
                       input string tag);
        launch(b, s, n, p, z);
        finish_run(b, s, n, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held and after release
        check(!mem_req && !busy && !done, "R1 idle flags", {29'd0, mem_req, busy, done}, 32'd0);
        check(addr_out == 0 && count_out == 0, "R1 zero regs", addr_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && addr_out == 0, "R1 after release", {31'd0, busy}, 32'd0);

        run(32'h100, 32'd1, 16'd6, 32'hA1B2C3D4, 2'd0, "R2 R8 byte walk");
        run(32'h203, 32'hFFFF_FFFE, 16'd5, 32'h1234_5678, 2'd1, "R3 R8 halfword back");
        run(32'h400, 32'h40, 16'd4, 32'hDEADBEEF, 2'd2, "R3 column dword");
        run(32'h5, 32'hFFFF_FFF9, 16'd3, 32'h0000_00EE, 2'd0, "R3 negative stride");
        run(32'h777, 32'd8, 16'd0, 32'h55, 2'd0, "R6 zero count");
        run(32'h81, 32'd3, 16'd1, 32'hCAFE_F00D, 2'd1, "R5 single store");
        run(32'hFFFF_FFF8, 32'd4, 16'd5, 32'h0BAD_CAFE, 2'd3, "R3 R8 wrap size3");

        // R9 R10: start pulse and input changes during a run are ignored
        launch(32'h1000, 32'd2, 16'd7, 32'h0102_0304, 2'd1);
        @(negedge clk);
        in_base = 32'h9999; in_stride = 32'd100; in_cnt = 16'd2;
        in_pat = 32'hFFFF_FFFF; in_size = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run(32'h1000, 32'd2, 16'd7, "R9 R10 ignored start");

        check(!busy && !done, "R7 back to idle", {30'd0, busy, done}, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule